// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block collects 72 level-sensitive interrupt sources into three banks and drives one interrupt request line toward a processor. Bank 0 carries 8 basic sources. Banks 1 and 2 carry 32 sources each. Every source has an enable bit held in its own bank. A pending register shows a source only while its input is high and its enable bit is set.

The bank 0 pending register is the summary view that software reads first. Bits 0-7 hold the basic sources. Bit 8 flags pending work in bank 1 and bit 9 flags pending work in bank 2. Bits 10-20 are shortcut bits: each one mirrors one selected bank 1 or bank 2 source, so software can find that source with a single read. A pending shortcut source shows up in its own bank register and in its shortcut bit, but it does not raise the summary bit of its bank. The summary bits have no mask of their own. A shortcut bit can be masked only through the enable bit in its home bank.

Software reaches the block through a simple register bus. The bus has a byte address, write data, a write strobe, a read strobe and registered read data. Every enable has a set address and a clear address, so a write changes only the bits written as 1.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset all enables are 0, `irq` is 0 and every register reads 0.
- R2: Writing 1s to a bank's enable-set address sets those enables, writing 1s to its enable-clear address clears them, and 0 bits change nothing. Both addresses read back the current mask. Set addresses: bank 0 at 0x18, bank 1 at 0x10, bank 2 at 0x14. Clear addresses: bank 0 at 0x24, bank 1 at 0x1c, bank 2 at 0x20.
- R3: The bank 1 pending register (0x04) and the bank 2 pending register (0x08) read source AND enable, bit for bit.
- R4: Bank 0 pending (0x00) bits 0-7 read basic source AND bank 0 enable. `irq` is high exactly when bank 0 pending is non-zero.
- R5: Bit 8 (bank 1) or bit 9 (bank 2) of bank 0 pending is 1 exactly when an enabled, active source of that bank that is not a shortcut source exists. A pending shortcut source alone leaves the bit at 0.
- R6: Bank 0 pending bits 10-14 mirror bank 1 pending bits 7, 9, 10, 18 and 19, in that order. Bits 15-20 mirror bank 2 pending bits 21, 22, 23, 24, 25 and 30, in that order.
- R7: Bank 0 enable writes at bit positions 8-31 have no effect, and those bits read 0. Shortcut and summary bits are gated only by the bank 1 and bank 2 enables.
- R8: Bank 0 pending bits 21-31 read 0. Addresses other than the nine listed read 0.
- R9: Pending bits are not latched: a pending bit falls to 0 as soon as its source input goes low.
- R10: `rdata` takes the addressed value at the clock edge where `rd_en` is sampled high, and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Byte address of the register access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata | output | 32 | Registered read data |
| src_basic | input | 8 | Bank 0 basic source levels |
| src_bank1 | input | 32 | Bank 1 source levels |
| src_bank2 | input | 32 | Bank 2 source levels |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: 8 basic sources, 32-bit banks and an 8-bit address. At these values every shortcut position and both summary bits fall inside one 32-bit word, so the bench can walk each of the eleven shortcut sources on its own. It can also mix a shortcut source with an ordinary source of the same bank, which shows that the summary bit is held back only when shortcut sources alone are pending. With every source high and every enable set, the bench checks that bank 0 pending reads exactly bits 0-20, which proves the unused top bits stay at 0.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int BASIC_N  = 8;
    localparam int WORD_W   = 32;
    localparam int SC1_N    = 5;
    localparam int SC2_N    = 6;
    localparam int SUM1_POS = BASIC_N;
    localparam int SUM2_POS = BASIC_N + 1;
    localparam int SC1_BASE = BASIC_N + 2;
    localparam int SC2_BASE = SC1_BASE + SC1_N;

    localparam logic [7:0] OFF_PEND0 = 8'h00;
    localparam logic [7:0] OFF_PEND1 = 8'h04;
    localparam logic [7:0] OFF_PEND2 = 8'h08;
    localparam logic [7:0] OFF_SET1  = 8'h10;
    localparam logic [7:0] OFF_SET2  = 8'h14;
    localparam logic [7:0] OFF_SET0  = 8'h18;
    localparam logic [7:0] OFF_CLR1  = 8'h1c;
    localparam logic [7:0] OFF_CLR2  = 8'h20;
    localparam logic [7:0] OFF_CLR0  = 8'h24;

    typedef logic [WORD_W-1:0] word_t;

    // Source index inside bank 1 mirrored by shortcut slot k
    function automatic int sc1_src(input int k);
        case (k)
            0:       return 7;
            1:       return 9;
            2:       return 10;
            3:       return 18;
            default: return 19;
        endcase
    endfunction

    // Source index inside bank 2 mirrored by shortcut slot k
    function automatic int sc2_src(input int k);
        if (k < 5) return 21 + k;
        return 30;
    endfunction

    function automatic word_t sc1_mask();
        word_t m = '0;
        for (int k = 0; k < SC1_N; k++) m[sc1_src(k)] = 1'b1;
        return m;
    endfunction

    function automatic word_t sc2_mask();
        word_t m = '0;
        for (int k = 0; k < SC2_N; k++) m[sc2_src(k)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irqc_enable_bank.sv
module irqc_enable_bank
    import irqc_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter logic [7:0]  SET_OFF = 8'h10,
    parameter logic [7:0]  CLR_OFF = 8'h1c,
    parameter word_t       WR_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    input  logic              wr_en,
    output word_t             en
);

    logic  hit_set, hit_clr;
    word_t wbits;

    always_comb begin
        hit_set = wr_en && (addr == ADDR_W'(SET_OFF));
        hit_clr = wr_en && (addr == ADDR_W'(CLR_OFF));
        wbits   = wdata & WR_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       en <= '0;
        else if (hit_set) en <= en | wbits;
        else if (hit_clr) en <= en & ~wbits;
    end

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        hit_set |=> ((en & $past(wbits)) == $past(wbits)));              // R2
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        hit_clr |=> ((en & $past(wbits)) == '0));                        // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_set || hit_clr) |=> $stable(en));                          // R2
    AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_set && ((wdata & WR_MASK) == '0)) |=> $stable(en));         // R7

endmodule

// File: rtl/irqc_bank0_view.sv
module irqc_bank0_view
    import irqc_pkg::*;
(
    input  logic [BASIC_N-1:0] basic_pend,
    input  word_t              pend1,
    input  word_t              pend2,
    output word_t              view
);

    localparam word_t SC1_M = sc1_mask();
    localparam word_t SC2_M = sc2_mask();

    word_t v;

    always_comb begin
        v                = '0;
        v[BASIC_N-1:0]   = basic_pend;
        v[SUM1_POS]      = |(pend1 & ~SC1_M);
        v[SUM2_POS]      = |(pend2 & ~SC2_M);
    end

    for (genvar k = 0; k < WORD_W; k++) begin : g_bit
        if (k >= SC1_BASE && k < SC1_BASE + SC1_N) begin : g_sc1
            assign view[k] = pend1[sc1_src(k - SC1_BASE)];
        end else if (k >= SC2_BASE && k < SC2_BASE + SC2_N) begin : g_sc2
            assign view[k] = pend2[sc2_src(k - SC2_BASE)];
        end else begin : g_plain
            assign view[k] = v[k];
        end
    end

    always_comb begin
        AST_SC_ALONE_NO_SUM1: assert (!(((pend1 & ~SC1_M) == '0) && view[SUM1_POS])); // R5
        AST_SC_ALONE_NO_SUM2: assert (!(((pend2 & ~SC2_M) == '0) && view[SUM2_POS])); // R5
    end

endmodule

// File: rtl/irqc_read_mux.sv
module irqc_read_mux
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  word_t             view0,
    input  word_t             pend1,
    input  word_t             pend2,
    input  word_t             en0,
    input  word_t             en1,
    input  word_t             en2,
    output word_t             rdata
);

    word_t sel;

    always_comb begin
        unique case (addr)
            ADDR_W'(OFF_PEND0):                    sel = view0;
            ADDR_W'(OFF_PEND1):                    sel = pend1;
            ADDR_W'(OFF_PEND2):                    sel = pend2;
            ADDR_W'(OFF_SET0), ADDR_W'(OFF_CLR0):  sel = en0;
            ADDR_W'(OFF_SET1), ADDR_W'(OFF_CLR1):  sel = en1;
            ADDR_W'(OFF_SET2), ADDR_W'(OFF_CLR2):  sel = en2;
            default:                               sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= sel;
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));                                      // R10
    AST_RD_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(OFF_PEND0)) |=> (rdata[WORD_W-1:SC2_BASE+SC2_N] == '0)); // R8

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [WORD_W-1:0]  wdata,
    input  logic               wr_en,
    input  logic               rd_en,
    output logic [WORD_W-1:0]  rdata,
    input  logic [BASIC_N-1:0] src_basic,
    input  logic [WORD_W-1:0]  src_bank1,
    input  logic [WORD_W-1:0]  src_bank2,
    output logic               irq
);

    localparam word_t B0_MASK = word_t'((1 << BASIC_N) - 1);
    localparam int    NBANK   = 3;
    localparam logic [7:0] SET_OFFS [NBANK] = '{OFF_SET0, OFF_SET1, OFF_SET2};
    localparam logic [7:0] CLR_OFFS [NBANK] = '{OFF_CLR0, OFF_CLR1, OFF_CLR2};

    word_t en [NBANK];
    word_t pend1, pend2, view0;
    logic [BASIC_N-1:0] basic_pend;

    for (genvar b = 0; b < NBANK; b++) begin : g_en
        irqc_enable_bank #(
            .ADDR_W (ADDR_W),
            .SET_OFF(SET_OFFS[b]),
            .CLR_OFF(CLR_OFFS[b]),
            .WR_MASK((b == 0) ? B0_MASK : '1)
        ) i_en (
            .clk  (clk),
            .rst_n(rst_n),
            .addr (addr),
            .wdata(wdata),
            .wr_en(wr_en),
            .en   (en[b])
        );
    end

    always_comb begin
        basic_pend = src_basic & en[0][BASIC_N-1:0];
        pend1      = src_bank1 & en[1];
        pend2      = src_bank2 & en[2];
    end

    irqc_bank0_view i_view (
        .basic_pend(basic_pend),
        .pend1     (pend1),
        .pend2     (pend2),
        .view      (view0)
    );

    assign irq = |view0;

    irqc_read_mux #(.ADDR_W(ADDR_W)) i_rd (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (addr),
        .rd_en(rd_en),
        .view0(view0),
        .pend1(pend1),
        .pend2(pend2),
        .en0  (en[0]),
        .en1  (en[1]),
        .en2  (en[2]),
        .rdata(rdata)
    );

    AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((src_basic != '0) || (src_bank1 != '0) || (src_bank2 != '0))); // R4
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((en[0] != '0) || (en[1] != '0) || (en[2] != '0)));             // R4
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (rdata == '0));                                              // R1

endmodule

// File: tb/test_banked_irq_ctrl.sv
module test_banked_irq_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic        wr_en, rd_en;
    logic [31:0] rdata;
    logic [7:0]  src_basic;
    logic [31:0] src_bank1, src_bank2;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench-side copy of the enable masks, updated from the requirements
    logic [31:0] m_en0, m_en1, m_en2;
    int sc1_list [5] = '{7, 9, 10, 18, 19};
    int sc2_list [6] = '{21, 22, 23, 24, 25, 30};

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_irq_ctrl i_banked_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
        .src_basic(src_basic), .src_bank1(src_bank1), .src_bank2(src_bank2),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_view0();
        logic [31:0] p1, p2, v;
        p1 = src_bank1 & m_en1;
        p2 = src_bank2 & m_en2;
        v = '0;
        v[7:0] = src_basic & m_en0[7:0];
        for (int k = 0; k < 5; k++) begin
            v[10+k] = p1[sc1_list[k]];
            p1[sc1_list[k]] = 1'b0;
        end
        for (int k = 0; k < 6; k++) begin
            v[15+k] = p2[sc2_list[k]];
            p2[sc2_list[k]] = 1'b0;
        end
        v[8] = |p1;
        v[9] = |p2;
        return v;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            8'h18: m_en0 = m_en0 | (d & 32'hff);
            8'h24: m_en0 = m_en0 & ~(d & 32'hff);
            8'h10: m_en1 = m_en1 | d;
            8'h1c: m_en1 = m_en1 & ~d;
            8'h14: m_en2 = m_en2 | d;
            8'h20: m_en2 = m_en2 & ~d;
            default: ;
        endcase
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic set_src(input logic [7:0] b0, input logic [31:0] b1, input logic [31:0] b2);
        @(negedge clk);
        src_basic = b0; src_bank1 = b1; src_bank2 = b2;
        #1;
    endtask

    task automatic t_reset;
        chk("R1 irq", {31'd0, irq}, 32'd0);
        foreach (sc1_list[i]) ;
        rd_chk(8'h00, 32'd0, "R1 pend0");
        rd_chk(8'h04, 32'd0, "R1 pend1");
        rd_chk(8'h08, 32'd0, "R1 pend2");
        rd_chk(8'h18, 32'd0, "R1 en0");
        rd_chk(8'h10, 32'd0, "R1 en1");
        rd_chk(8'h20, 32'd0, "R1 en2");
    endtask

    task automatic t_enable;
        wr(8'h10, 32'hf0f0_00ff);
        rd_chk(8'h10, 32'hf0f0_00ff, "R2 set1 readback");
        rd_chk(8'h1c, 32'hf0f0_00ff, "R2 clr1 readback");
        wr(8'h1c, 32'h0000_00f0);
        rd_chk(8'h10, 32'hf0f0_000f, "R2 clear bits");
        wr(8'h10, 32'h0);
        rd_chk(8'h10, 32'hf0f0_000f, "R2 zero write");
        wr(8'h14, 32'h1234_5678);
        rd_chk(8'h20, 32'h1234_5678, "R2 set2");
        wr(8'h18, 32'h0000_00a5);
        rd_chk(8'h24, 32'h0000_00a5, "R2 set0");
        wr(8'h24, 32'h0000_0005);
        rd_chk(8'h18, 32'h0000_00a0, "R2 clr0");
    endtask

    task automatic t_bank_pend;
        set_src(8'h00, 32'hffff_ffff, 32'h0f0f_0f0f);
        rd_chk(8'h04, 32'hffff_ffff & m_en1, "R3 pend1");
        rd_chk(8'h08, 32'h0f0f_0f0f & m_en2, "R3 pend2");
        set_src(8'h00, 32'h0, 32'h0);
    endtask

    task automatic t_basic;
        wr(8'h24, 32'hff); wr(8'h1c, 32'hffff_ffff); wr(8'h20, 32'hffff_ffff);
        wr(8'h18, 32'h0f);
        set_src(8'h33, 32'h0, 32'h0);
        chk("R4 irq basic", {31'd0, irq}, 32'd1);
        rd_chk(8'h00, 32'h3, "R4 basic masked");
        set_src(8'h30, 32'h0, 32'h0);
        chk("R4 irq masked", {31'd0, irq}, 32'd0);
        rd_chk(8'h00, 32'h0, "R4 pend0 masked");
        set_src(8'h00, 32'h0, 32'h0);
    endtask

    task automatic t_summary;
        wr(8'h10, 32'hffff_ffff); wr(8'h14, 32'hffff_ffff);
        set_src(8'h0, 32'h1, 32'h0);
        rd_chk(8'h00, 32'h100, "R5 sum1 plain");
        set_src(8'h0, 32'h80, 32'h0);
        rd_chk(8'h00, 32'h400, "R5 shortcut alone no sum1");
        set_src(8'h0, 32'h88, 32'h0);
        rd_chk(8'h00, 32'h500, "R5 mixed sum1");
        set_src(8'h0, 32'h0, 32'h4000_0000);
        rd_chk(8'h00, 32'h10_0000, "R5 shortcut alone no sum2");
        set_src(8'h0, 32'h0, 32'h8000_0000);
        rd_chk(8'h00, 32'h200, "R5 sum2 plain");
        chk("R5 irq from summary", {31'd0, irq}, 32'd1);
        set_src(8'h0, 32'h0, 32'h0);
    endtask

    task automatic t_shortcut;
        for (int k = 0; k < 5; k++) begin
            set_src(8'h0, 32'h1 << sc1_list[k], 32'h0);
            rd_chk(8'h00, 32'h1 << (10 + k), "R6 bank1 shortcut");
            rd_chk(8'h04, 32'h1 << sc1_list[k], "R6 bank1 own bit");
        end
        for (int k = 0; k < 6; k++) begin
            set_src(8'h0, 32'h0, 32'h1 << sc2_list[k]);
            rd_chk(8'h00, 32'h1 << (15 + k), "R6 bank2 shortcut");
        end
        set_src(8'h0, 32'h0, 32'h0);
    endtask

    task automatic t_b0_mask;
        wr(8'h18, 32'hffff_ff00);
        rd_chk(8'h18, m_en0, "R7 upper set ignored");
        wr(8'h1c, 32'h80);
        set_src(8'h0, 32'h80, 32'h0);
        chk("R7 home mask gates irq", {31'd0, irq}, 32'd0);
        rd_chk(8'h00, 32'h0, "R7 home mask gates shortcut");
        wr(8'h10, 32'h80);
        wr(8'h24, 32'hffff_ff00);
        rd_chk(8'h00, 32'h400, "R7 bank0 clear no effect on shortcut");
        set_src(8'h0, 32'h0, 32'h0);
    endtask

    task automatic t_top_zero;
        wr(8'h18, 32'hff);
        set_src(8'hff, 32'hffff_ffff, 32'hffff_ffff);
        rd_chk(8'h00, 32'h001f_ffff, "R8 upper bits zero");
        chk("R8 model agrees", 32'h001f_ffff, model_view0());
        rd_chk(8'h0c, 32'h0, "R8 hole 0x0c");
        rd_chk(8'h28, 32'h0, "R8 hole 0x28");
        // R10: read data holds while sources change
        set_src(8'h00, 32'h0, 32'h0);
        repeat (3) @(negedge clk);
        #1;
        chk("R10 rdata holds", rdata, 32'h0);
        rd_chk(8'h00, 32'h0, "R9 level drop clears pend0");
        rd_chk(8'h04, 32'h0, "R9 level drop clears pend1");
        chk("R9 irq drops", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_level;
        set_src(8'h01, 32'h0000_0100, 32'h0);
        rd_chk(8'h00, model_view0(), "R9 level high");
        set_src(8'h00, 32'h0000_0100, 32'h0);
        rd_chk(8'h00, model_view0(), "R9 basic falls");
        set_src(8'h00, 32'h0, 32'h0);
    endtask

    initial begin
        rst_n = 1'b0; addr = '0; wdata = '0; wr_en = 1'b0; rd_en = 1'b0;
        src_basic = '0; src_bank1 = '0; src_bank2 = '0;
        m_en0 = '0; m_en1 = '0; m_en2 = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_enable();
        t_bank_pend();
        t_basic();
        t_summary();
        t_shortcut();
        t_b0_mask();
        t_level();
        t_top_zero();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule